// File: doc/BRIEF.md
# Scalar Data-Memory Access Stage

This block is the data-memory stage of a short in-order pipeline. Each cycle it takes the request held in the execute-to-memory latch and performs it against a 4 KiB data memory organised as 32-bit words. It then loads the writeback latch with a result and a destination register index. The block does not align or extend data. The execute stage prepares a read mask, a write mask, store data already placed in its byte lanes, and a right-shift amount. The block applies these to the selected memory word without further interpretation.

A scalar request does two things on the same word in one cycle. It reads the word, shifts it arithmetically right and masks it to form the load result. It also writes the word back with the store bytes merged in under the write mask. A pure load carries a zero write mask, so the write-back leaves the word as it was. A pure store carries a zero read mask, so the load result is zero. A request of kind none passes the upstream result and destination through and leaves memory alone. A vector request does the same, except that the destination index is forced to 0 so that no scalar register is written.

The request kind works as the block's decode state: `REQ_IDLE` (code 0), `REQ_SCALAR` (code 1), and the two vector codes `REQ_VEC_A` (2) and `REQ_VEC_B` (3). A new kind is decoded on every clock, and any kind may follow any other. Each transition is taken on the rising edge where the writeback latch captures the outcome of the kind presented in the cycle before.

Top module: `dmem_stage`

## Requirements
- R1: While `rst_n` is low, `wb_result` and `wb_dest` are 0.
- R2: A request with `req_kind` = 0 sets `wb_result` to `ex_result` and `wb_dest` to `ex_dest` at the next rising edge, and it leaves every memory word unchanged.
- R3: Only address bits 11:2 select the memory word. Bits 31:12 and bits 1:0 of `req_addr` have no effect.
- R4: A request with `req_kind` = 1 sets `wb_result` at the next rising edge to `rd_mask` AND (the selected word taken as signed and shifted arithmetically right by `rshift`). It also sets `wb_dest` to `ex_dest`. With `rd_mask` = 0 the result is 0.
- R5: A request with `req_kind` = 1 writes (old word AND NOT `wr_mask`) OR (`st_data` AND `wr_mask`) at the same rising edge. A request in the very next cycle sees the new word.
- R6: Memory is big-endian. The byte at offset k (address bits 1:0 = k) sits in word bits [31-8k : 24-8k]. A byte store through mask 0xFF << (24-8k) is read back by a load with shift 24-8k and mask 0xFF.
- R7: A request with `req_kind` = 2 or 3 sets `wb_dest` to 0 and `wb_result` to `ex_result`, and it leaves memory unchanged.
- R8: When one scalar request both loads and stores, the load result is taken from the word as it was before the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_kind | input | 2 | Request kind: 0 none, 1 scalar, 2 or 3 vector |
| req_addr | input | 32 | Byte address of the access |
| rd_mask | input | 32 | Mask applied to the shifted load word |
| wr_mask | input | 32 | Bit mask selecting which bits the store replaces |
| st_data | input | 32 | Store data already placed in its lanes |
| rshift | input | 5 | Arithmetic right-shift amount for the load |
| ex_result | input | 32 | Result passed from the execute latch |
| ex_dest | input | 5 | Destination register index from the execute latch |
| wb_result | output | 32 | Writeback latch result |
| wb_dest | output | 5 | Writeback latch destination index |

## Verification
Errors in the word index, the merge or the decoded kind all end up in memory. They surface at the ports only when a later load reads the damaged word, which may be many cycles after the faulty write. The bench therefore reads back every word it has stored, soon and repeatedly. It also loads in the cycle right after a store, to catch a lost or late write. A wrong kind decode or a bad shift shows up one cycle later on `wb_result` or `wb_dest`, and the per-clock comparison catches it there.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [1:0] {
        REQ_IDLE   = 2'd0,
        REQ_SCALAR = 2'd1,
        REQ_VEC_A  = 2'd2,
        REQ_VEC_B  = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic        mem_we;
        logic        take_load;
        logic        clear_dest;
    } stage_ctl_t;

endpackage

// File: rtl/dmem_word_ram.sv
module dmem_word_ram #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    localparam int WORDS = 1 << IDX_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] rd_word,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_word
);

    logic [DATA_W-1:0] cells [WORDS];

    // combinational read of the word as it stands before this edge
    assign rd_word = cells[idx];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wr_word;
        end
    end

endmodule

// File: rtl/dmem_load_shape.sv
module dmem_load_shape #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [SH_W-1:0]   rshift,
    input  logic [DATA_W-1:0] rd_mask,
    output logic [DATA_W-1:0] ld_val
);

    logic signed [DATA_W-1:0] shifted;

    assign shifted = $signed(word) >>> rshift;
    assign ld_val  = rd_mask & shifted;

endmodule

// File: rtl/dmem_store_merge.sv
module dmem_store_merge #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] merged
);

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        assign merged[lane*8 +: 8] = (old_word[lane*8 +: 8] & ~wr_mask[lane*8 +: 8])
                                   | (st_data[lane*8 +: 8]  &  wr_mask[lane*8 +: 8]);
    end

endmodule

// File: rtl/dmem_stage.sv
module dmem_stage #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int REG_W      = 5,
    parameter int REQ_ADDR_W = 32,
    localparam int SEL_W     = $clog2(DATA_W / 8),
    localparam int IDX_W     = ADDR_W - SEL_W,
    localparam int SH_W      = $clog2(DATA_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            req_kind,
    input  logic [REQ_ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]     rd_mask,
    input  logic [DATA_W-1:0]     wr_mask,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [SH_W-1:0]       rshift,
    input  logic [DATA_W-1:0]     ex_result,
    input  logic [REG_W-1:0]      ex_dest,
    output logic [DATA_W-1:0]     wb_result,
    output logic [REG_W-1:0]      wb_dest
);

    import dmem_pkg::*;

    req_kind_e          kind_c;
    stage_ctl_t         ctl;
    logic [IDX_W-1:0]   word_idx;
    logic [DATA_W-1:0]  old_word;
    logic [DATA_W-1:0]  new_word;
    logic [DATA_W-1:0]  ld_val;
    logic [DATA_W-1:0]  nxt_result;
    logic [REG_W-1:0]   nxt_dest;
    logic               mem_we;
    logic               unused_addr_bits;

    assign kind_c   = req_kind_e'(req_kind);
    assign word_idx = req_addr[ADDR_W-1:SEL_W];
    assign unused_addr_bits = ^{req_addr[REQ_ADDR_W-1:ADDR_W], req_addr[SEL_W-1:0]};

    dmem_word_ram #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_ram (
        .clk     (clk),
        .idx     (word_idx),
        .rd_word (old_word),
        .we      (mem_we),
        .wr_word (new_word)
    );

    dmem_load_shape #(
        .DATA_W (DATA_W)
    ) u_shape (
        .word    (old_word),
        .rshift  (rshift),
        .rd_mask (rd_mask),
        .ld_val  (ld_val)
    );

    dmem_store_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .old_word (old_word),
        .st_data  (st_data),
        .wr_mask  (wr_mask),
        .merged   (new_word)
    );

    // request-kind decode
    always_comb begin
        ctl = '0;
        unique case (kind_c)
            REQ_IDLE:   ctl = '{mem_we: 1'b0, take_load: 1'b0, clear_dest: 1'b0};
            REQ_SCALAR: ctl = '{mem_we: 1'b1, take_load: 1'b1, clear_dest: 1'b0};
            REQ_VEC_A,
            REQ_VEC_B:  ctl = '{mem_we: 1'b0, take_load: 1'b0, clear_dest: 1'b1};
        endcase
    end

    assign mem_we     = ctl.mem_we;
    assign nxt_result = ctl.take_load  ? ld_val : ex_result;
    assign nxt_dest   = ctl.clear_dest ? '0     : ex_dest;

    // writeback latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_result <= '0;
            wb_dest   <= '0;
        end else begin
            wb_result <= nxt_result;
            wb_dest   <= nxt_dest;
        end
    end

endmodule

// File: rtl/dmem_stage_chk.sv
module dmem_stage_chk #(
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        req_kind,
    input logic [DATA_W-1:0] rd_mask,
    input logic [DATA_W-1:0] ex_result,
    input logic [REG_W-1:0]  ex_dest,
    input logic [DATA_W-1:0] wb_result,
    input logic [REG_W-1:0]  wb_dest
);

    always @(posedge clk) begin
        if (!rst_n) begin
            // R1
            rst_state_chk: assert (wb_result == '0 && wb_dest == '0);
        end
    end

    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_kind == 2'd0 |=> (wb_result == $past(ex_result) && wb_dest == $past(ex_dest)));

    // R7
    vec_dest_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_kind[1] |=> wb_dest == '0);

    // R7
    vec_result_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_kind[1] |=> wb_result == $past(ex_result));

    // R4
    scalar_dest_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_kind == 2'd1 |=> wb_dest == $past(ex_dest));

    // R4
    zero_rdmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == 2'd1 && rd_mask == '0) |=> wb_result == '0);

endmodule

bind dmem_stage dmem_stage_chk #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_kind  (req_kind),
    .rd_mask   (rd_mask),
    .ex_result (ex_result),
    .ex_dest   (ex_dest),
    .wb_result (wb_result),
    .wb_dest   (wb_dest)
);

// File: tb/dmem_stage_tb_top.sv
module dmem_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  req_kind;
    logic [31:0] req_addr, rd_mask, wr_mask, st_data, ex_result;
    logic [4:0]  rshift, ex_dest;
    logic [31:0] wb_result;
    logic [4:0]  wb_dest;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [31:0] ref_mem [1024];

    always #4 clk = ~clk;

    dmem_stage dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .rd_mask   (rd_mask),
        .wr_mask   (wr_mask),
        .st_data   (st_data),
        .rshift    (rshift),
        .ex_result (ex_result),
        .ex_dest   (ex_dest),
        .wb_result (wb_result),
        .wb_dest   (wb_dest)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one request per clock; called at a falling edge, returns at the next one
    task automatic issue(input string req, input logic [1:0] k, input logic [31:0] a,
                         input logic [31:0] rm, input logic [31:0] wm, input logic [31:0] d,
                         input logic [4:0] sh, input logic [31:0] exr, input logic [4:0] exd);
        logic [31:0] exp_r, w;
        logic [4:0]  exp_d;
        int          idx;
        req_kind = k; req_addr = a; rd_mask = rm; wr_mask = wm;
        st_data = d; rshift = sh; ex_result = exr; ex_dest = exd;
        idx = int'(a[11:2]);
        if (k == 2'd0) begin
            exp_r = exr; exp_d = exd;
        end else if (k == 2'd1) begin
            w     = ref_mem[idx];
            exp_r = rm & 32'($signed(w) >>> sh);
            exp_d = exd;
            ref_mem[idx] = (w & ~wm) | (d & wm);
        end else begin
            exp_r = exr; exp_d = 5'd0;
        end
        @(negedge clk);
        check({req, " result"}, wb_result, exp_r);
        check({req, " dest"}, 32'(wb_dest), 32'(exp_d));
    endtask

    task automatic store_word(input logic [31:0] a, input logic [31:0] d);
        issue("R5", 2'd1, a, 32'h0, 32'hFFFF_FFFF, d, 5'd0, 32'h0, 5'd1);
    endtask

    task automatic load_word(input string req, input logic [31:0] a);
        issue(req, 2'd1, a, 32'hFFFF_FFFF, 32'h0, 32'h0, 5'd0, 32'h0, 5'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        req_kind = 2'd0; req_addr = '0; rd_mask = '0; wr_mask = '0;
        st_data = '0; rshift = '0; ex_result = '0; ex_dest = '0;
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset result", wb_result, 32'h0);
        check("R1 reset dest", 32'(wb_dest), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 16; i++) begin
            store_word(32'(i * 4), 32'hA500_0000 + 32'(i * 32'h0101_0101));
        end
        // pure store yields zero result (R4)
        check("R4 store result zero", wb_result, 32'h0);

        store_word(32'h0000_0040, 32'h80F1_7E02);
        load_word("R4 word", 32'h0000_0040);
        check("R4 word value", wb_result, 32'h80F1_7E02);

        // signed byte at offset 0 (R6)
        issue("R6", 2'd1, 32'h41, 32'hFFFF_FFFF, 0, 0, 5'd24, 0, 5'd3);
        check("R6 signed byte", wb_result, 32'hFFFF_FF80);
        // unsigned byte at offset 2
        issue("R6", 2'd1, 32'h42, 32'h0000_00FF, 0, 0, 5'd8, 0, 5'd3);
        check("R6 unsigned byte", wb_result, 32'h0000_007E);
        // signed halfword at offset 0
        issue("R4", 2'd1, 32'h40, 32'hFFFF_FFFF, 0, 0, 5'd16, 0, 5'd4);
        check("R4 signed half", wb_result, 32'hFFFF_80F1);
        // unsigned halfword at offset 2
        issue("R4", 2'd1, 32'h42, 32'h0000_FFFF, 0, 0, 5'd0, 0, 5'd4);
        check("R4 unsigned half", wb_result, 32'h0000_7E02);

        // byte store at offset 1, then reread next cycle (R6, R5)
        issue("R6", 2'd1, 32'h41, 32'h0, 32'h00FF_0000, 32'h0033_0000, 5'd0, 0, 5'd0);
        issue("R6", 2'd1, 32'h41, 32'h0000_00FF, 0, 0, 5'd16, 0, 5'd5);
        check("R6 byte store readback", wb_result, 32'h0000_0033);
        // halfword store at offset 2
        issue("R5", 2'd1, 32'h42, 32'h0, 32'h0000_FFFF, 32'h0000_BEEF, 5'd0, 0, 5'd0);
        load_word("R5 half store", 32'h40);
        check("R5 half store word", wb_result, 32'h8033_BEEF);

        // R8: combined load and store in one request returns old word
        issue("R8", 2'd1, 32'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678, 5'd0, 0, 5'd6);
        check("R8 old word", wb_result, 32'h8033_BEEF);
        load_word("R5 next cycle", 32'h40);
        check("R5 new word", wb_result, 32'h1234_5678);

        // R3: aliasing through ignored address bits
        load_word("R3 alias", 32'hABCD_E043);
        check("R3 alias value", wb_result, 32'h1234_5678);
        issue("R3", 2'd1, 32'hFFFF_F002, 32'h0, 32'hFFFF_FFFF, 32'h0BAD_F00D, 5'd0, 0, 5'd0);
        load_word("R3 alias store", 32'h0);
        check("R3 alias store value", wb_result, 32'h0BAD_F00D);

        // R2: idle request with live masks leaves memory alone
        issue("R2", 2'd0, 32'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 5'd3, 32'hCAFE_0001, 5'd9);
        check("R2 pass result", wb_result, 32'hCAFE_0001);
        check("R2 pass dest", 32'(wb_dest), 32'd9);
        load_word("R2 memory kept", 32'h40);
        check("R2 memory value", wb_result, 32'h1234_5678);

        // R7: both vector codes clear dest and keep memory
        issue("R7", 2'd2, 32'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 5'd0, 32'h5555_AAAA, 5'd7);
        check("R7 dest cleared", 32'(wb_dest), 32'd0);
        check("R7 result pass", wb_result, 32'h5555_AAAA);
        issue("R7", 2'd3, 32'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 5'd0, 32'h0000_0011, 5'd31);
        check("R7 code3 dest", 32'(wb_dest), 32'd0);
        load_word("R7 memory kept", 32'h40);
        check("R7 memory value", wb_result, 32'h1234_5678);

        // mixed random traffic over the first 16 words
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  k;
            logic [31:0] a;
            k = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 0) k = 2'd1;
            a = {$urandom()} & 32'hFFFF_F03F;
            issue("R4 R5 random", k, a, $urandom(), $urandom(), $urandom(),
                  5'($urandom_range(0, 31)), $urandom(), 5'($urandom_range(0, 31)));
        end

        summary();
    end

endmodule